// File: doc/BRIEF.md
# Dual-Clock FIFO with Two-Bit Occupancy Code

This block is a first-in first-out buffer of 512 words of 9 bits that sits between two unrelated clock domains. A producer writes on its own free-running clock with an active-low write enable, and a consumer reads on a second free-running clock with an active-low read enable. Each pointer travels to the opposite domain as a Gray code through a two-stage synchronizer. Each side therefore judges occupancy from its own pointer and a delayed copy of the other side's pointer.

Occupancy is reported as a two-bit code. The low-level states (empty, nearly empty) are registered only on read-clock edges. The high-level state (nearly full) is registered only on write-clock edges. A full condition is kept inside the write domain to block writes, but it is not driven out. A read-clock edge that finds the code at Empty is a flag-only cycle: it refreshes the code and moves no data, whatever the read enable. The consumer therefore sees the first word on the enabled read that follows that refresh. A single active-low master reset empties the buffer.

Top module: `cdc_fifo_occ`

## Requirements
- R1: `occ_code` encodes four levels: 2'b00 empty (0 words), 2'b10 nearly empty (1 to 16), 2'b11 middle (17 to 495), 2'b01 nearly full or full (496 to 512). The two low levels follow the read side's view of occupancy; the nearly-full level follows the write side's view and is shown only when the read side sees more than 16 words.
- R2: A word is stored on a rising `wr_clk` edge when `wr_en_n` is 0 and the internal full condition is clear. Once 512 words are held, further writes are dropped and the stored words are left untouched.
- R3: A word is removed on a rising `rd_clk` edge when `rd_en_n` is 0 and `occ_code` was not 2'b00 before that edge. `rd_data` then shows that word, and words leave in the order they were written.
- R4: Writes never clear an Empty code by themselves. A write pointer update first reaches the read flags on the third rising `rd_clk` edge after it (two synchronizer stages, then the flag register).
- R5: A rising `rd_clk` edge that finds `occ_code` at 2'b00 only refreshes the code. It removes no word and leaves `rd_data` unchanged, with `rd_en_n` either 0 or 1.
- R6: The nearly-full level is set and cleared only on rising `wr_clk` edges. After reads, it stays until write-clock edges carry the read pointer across, which takes three edges. A write edge with `wr_en_n` at 1 refreshes the code without storing a word.
- R7: While nothing is read, `rd_data` holds the last word read, including on every edge taken while empty.
- R8: While `rst_n` is 0, both pointers are cleared, `occ_code` is 2'b00 and `rd_data` is all zeros. The reset is applied asynchronously and released in step with each clock.
- R9: A single flag refresh out of Empty may jump straight to 2'b01 when the write side already sees 496 or more words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock, free running |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 9 | Word to store |
| rd_clk | input | 1 | Read-side clock, free running |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 9 | Registered output word |
| rst_n | input | 1 | Master reset, active low |
| occ_code | output | 2 | Occupancy code, bit 1 first flag, bit 0 second flag |

## Verification
Three things can land on one read-clock edge: the flag refresh, an enabled read, and a write pointer that has just crossed the synchronizer. Random enables on two clocks of unrelated period (20 ns and 26 ns) make these collide often. The bench judges each such edge by one rule: from the code seen before the edge and the enable, it predicts whether a word leaves. That word is checked against a queue model, and the code is checked against occupancy bounds from that model. Directed phases stop one clock to count the exact edges: the latency out of Empty (with the enable inactive, and also straight to nearly full), the retention of nearly full, and the full boundary.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'b00,
    OCC_HIGH  = 2'b01,
    OCC_LOW   = 2'b10,
    OCC_MID   = 2'b11
  } occ_code_e;

  typedef struct packed {
    logic empty;
    logic low;
  } rd_lvl_t;

endpackage

// File: rtl/cdc_fifo_rst_sync.sv
module cdc_fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];

endmodule

// File: rtl/cdc_fifo_ptr_sync.sv
module cdc_fifo_ptr_sync #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);

  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc      = acc ^ sync_q[i];
      bin_o[i] = acc;
    end
  end

endmodule

// File: rtl/cdc_fifo_ram.sv
module cdc_fifo_ram #(
  parameter int DW = 9,
  parameter int AW = 9
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cdc_fifo_wr_side.sv
module cdc_fifo_wr_side #(
  parameter int AW       = 9,
  parameter int HIGH_LVL = 496
) (
  input  logic        wr_clk,
  input  logic        rst_n,
  input  logic        wr_en_n,
  input  logic [AW:0] rbin_s,
  output logic [AW:0] wbin_o,
  output logic [AW:0] wgray_o,
  output logic        wr_fire_o,
  output logic        high_o
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(1 << AW);
  localparam logic [PW-1:0] HIGH_CNT = PW'(HIGH_LVL);

  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic [PW-1:0] occ_w, occ_nx;
  logic          full_q, full_d;
  logic          high_q, high_d;
  logic          wr_fire;

  always_comb begin
    occ_w   = wbin_q - rbin_s;
    wr_fire = !wr_en_n && !full_q;
    wbin_d  = wbin_q + PW'(wr_fire);
    wgray_d = wbin_d ^ (wbin_d >> 1);
    occ_nx  = occ_w + PW'(wr_fire);
    full_d  = (occ_nx == FULL_CNT);
    high_d  = (occ_nx >= HIGH_CNT);
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      high_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      high_q  <= high_d;
    end
  end

  assign wbin_o    = wbin_q;
  assign wgray_o   = wgray_q;
  assign wr_fire_o = wr_fire;
  assign high_o    = high_q;

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_fire |-> (occ_w < FULL_CNT)); // R2

  AST_FULL_FREEZES_PTR: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full_q |=> $stable(wbin_q)); // R2

  AST_GRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R4

endmodule

// File: rtl/cdc_fifo_rd_side.sv
module cdc_fifo_rd_side
  import cdc_fifo_pkg::*;
#(
  parameter int DW      = 9,
  parameter int AW      = 9,
  parameter int LOW_LVL = 16
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic [AW:0]   wbin_s,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW:0]   rbin_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rd_data_o,
  output rd_lvl_t       lvl_o
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] LOW_CNT = PW'(LOW_LVL);

  logic [PW-1:0] rbin_q, rbin_d;
  logic [PW-1:0] rgray_q, rgray_d;
  logic [PW-1:0] occ_r, occ_nx;
  logic [DW-1:0] data_q, data_d;
  rd_lvl_t       lvl_q, lvl_d;
  logic          rd_fire;

  always_comb begin
    occ_r       = wbin_s - rbin_q;
    rd_fire     = !rd_en_n && !lvl_q.empty;
    rbin_d      = rbin_q + PW'(rd_fire);
    rgray_d     = rbin_d ^ (rbin_d >> 1);
    occ_nx      = wbin_s - rbin_d;
    lvl_d.empty = (occ_nx == '0);
    lvl_d.low   = (occ_nx != '0) && (occ_nx <= LOW_CNT);
    data_d      = rd_fire ? ram_rdata : data_q;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
      lvl_q   <= '{empty: 1'b1, low: 1'b0};
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      data_q  <= data_d;
      lvl_q   <= lvl_d;
    end
  end

  assign rbin_o    = rbin_q;
  assign rgray_o   = rgray_q;
  assign rd_data_o = data_q;
  assign lvl_o     = lvl_q;

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_fire |-> (occ_r != '0)); // R3

  AST_EMPTY_LATENT: assert property (@(posedge rd_clk) disable iff (!rst_n)
    lvl_q.empty |=> $stable(rbin_q)); // R5

  AST_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rbin_d == rbin_q) |=> $stable(data_q)); // R7

  AST_LEVELS_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(lvl_q.empty && lvl_q.low)); // R1

endmodule

// File: rtl/cdc_fifo_occ.sv
module cdc_fifo_occ
  import cdc_fifo_pkg::*;
#(
  parameter int DW          = 9,
  parameter int AW          = 9,
  parameter int LOW_LVL     = 16,
  parameter int HIGH_MARGIN = 16
) (
  input  logic          wr_clk,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  input  logic          rst_n,
  output logic [1:0]    occ_code
);

  localparam int PW       = AW + 1;
  localparam int HIGH_LVL = (1 << AW) - HIGH_MARGIN;

  logic          wr_rst_n, rd_rst_n;
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wbin_s, rbin_s;
  logic          wr_fire, wr_high;
  logic [DW-1:0] ram_rdata;
  rd_lvl_t       rd_lvl;
  occ_code_e     code;

  cdc_fifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .rst_n_o(wr_rst_n));
  cdc_fifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .rst_n_o(rd_rst_n));

  cdc_fifo_wr_side #(.AW(AW), .HIGH_LVL(HIGH_LVL)) u_wr (
    .wr_clk   (wr_clk),
    .rst_n    (wr_rst_n),
    .wr_en_n  (wr_en_n),
    .rbin_s   (rbin_s),
    .wbin_o   (wbin),
    .wgray_o  (wgray),
    .wr_fire_o(wr_fire),
    .high_o   (wr_high)
  );

  cdc_fifo_ptr_sync #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .gray_i(rgray), .bin_o(rbin_s)
  );

  cdc_fifo_ptr_sync #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_i(wgray), .bin_o(wbin_s)
  );

  cdc_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk(wr_clk),
    .we    (wr_fire),
    .waddr (wbin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rbin[AW-1:0]),
    .rdata (ram_rdata)
  );

  cdc_fifo_rd_side #(.DW(DW), .AW(AW), .LOW_LVL(LOW_LVL)) u_rd (
    .rd_clk   (rd_clk),
    .rst_n    (rd_rst_n),
    .rd_en_n  (rd_en_n),
    .wbin_s   (wbin_s),
    .ram_rdata(ram_rdata),
    .rbin_o   (rbin),
    .rgray_o  (rgray),
    .rd_data_o(rd_data),
    .lvl_o    (rd_lvl)
  );

  always_comb begin
    if (rd_lvl.empty)    code = OCC_EMPTY;
    else if (rd_lvl.low) code = OCC_LOW;
    else if (wr_high)    code = OCC_HIGH;
    else                 code = OCC_MID;
  end

  assign occ_code = code;

endmodule

// File: tb/cdc_fifo_occ_tb_top.sv
`timescale 1ns/1ps
module cdc_fifo_occ_tb_top;

  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       wr_run = 1'b1;
  logic       rd_run = 1'b1;
  logic       rst_n  = 1'b0;
  logic       wr_en_n = 1'b1;
  logic       rd_en_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic [1:0] occ_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [8:0] model_q[$];

  cdc_fifo_occ dut_i (
    .wr_clk  (wr_clk),
    .wr_en_n (wr_en_n),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_en_n (rd_en_n),
    .rd_data (rd_data),
    .rst_n   (rst_n),
    .occ_code(occ_code)
  );

  // 50 MHz write clock, 26 ns read clock; each stops low when its run flag drops
  always begin
    #10;
    if (wr_run || wr_clk) wr_clk = ~wr_clk;
  end
  always begin
    #13;
    if (rd_run || rd_clk) rd_clk = ~rd_clk;
  end

  function automatic logic [8:0] pat(int i);
    return 9'((i * 7 + 3) % 512);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_edges(int n);
    rd_run = 1'b1;
    repeat (n) @(negedge rd_clk);
    rd_run = 1'b0;
  endtask

  task automatic wr_edges(int n);
    wr_run = 1'b1;
    repeat (n) @(negedge wr_clk);
    wr_run = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    repeat (5) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] last;
    logic [8:0] exp_w;
    bit rnd_done;

    // ---------- reset ----------
    do_reset();
    @(negedge rd_clk);
    chk(occ_code == 2'b00, "R8 code after reset", occ_code, 0);
    chk(rd_data == 9'd0, "R8 data after reset", rd_data, 0);

    // ---------- fill past full with the read clock stopped ----------
    rd_run = 1'b0;
    wait (rd_clk == 1'b0);
    @(negedge wr_clk);
    for (int i = 0; i < 520; i++) begin
      wr_en_n = 1'b0;
      wr_data = pat(i);
      @(negedge wr_clk);
    end
    wr_en_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    chk(occ_code == 2'b00, "R4 empty held without read edges", occ_code, 0);

    rd_en_n = 1'b0;
    rd_edges(1);
    chk(occ_code == 2'b00, "R4 edge1 still empty", occ_code, 0);
    chk(rd_data == 9'd0, "R5 edge1 no data", rd_data, 0);
    rd_edges(1);
    chk(occ_code == 2'b00, "R4 edge2 still empty", occ_code, 0);
    rd_edges(1);
    chk(occ_code == 2'b01, "R9 latent edge jumps to nearly full", occ_code, 1);
    chk(rd_data == 9'd0, "R5 latent edge moves no data", rd_data, 0);

    // ---------- read 20 with the write clock stopped ----------
    wr_run = 1'b0;
    wait (wr_clk == 1'b0);
    for (int k = 0; k < 20; k++) begin
      rd_edges(1);
      chk(rd_data == pat(k), "R3 order", rd_data, pat(k));
    end
    rd_en_n = 1'b1;
    chk(occ_code == 2'b01, "R6 nearly full held by write domain", occ_code, 1);
    wr_edges(2);
    chk(occ_code == 2'b01, "R6 two write edges not yet", occ_code, 1);
    wr_edges(1);
    chk(occ_code == 2'b11, "R6 write edge enable high refreshes", occ_code, 3);

    // ---------- drain, level boundaries ----------
    rd_en_n = 1'b0;
    for (int k = 20; k < 512; k++) begin
      rd_edges(1);
      chk(rd_data == pat(k), "R3 order drain", rd_data, pat(k));
      if (511 - k == 17) chk(occ_code == 2'b11, "R1 17 words middle", occ_code, 3);
      if (511 - k == 16) chk(occ_code == 2'b10, "R1 16 words nearly empty", occ_code, 2);
      if (511 - k == 1)  chk(occ_code == 2'b10, "R1 1 word nearly empty", occ_code, 2);
    end
    chk(occ_code == 2'b00, "R2 exactly 512 stored then empty", occ_code, 0);
    rd_edges(3);
    chk(rd_data == pat(511), "R7 hold last word while empty", rd_data, pat(511));
    chk(occ_code == 2'b00, "R5 empty edges keep empty", occ_code, 0);

    // ---------- latent refresh with read enable inactive ----------
    rd_en_n = 1'b1;
    wr_run = 1'b1;
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = 9'h155;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    rd_edges(2);
    chk(occ_code == 2'b00, "R4 two read edges still empty", occ_code, 0);
    rd_edges(1);
    chk(occ_code == 2'b10, "R5 refresh with enable high", occ_code, 2);
    chk(rd_data == pat(511), "R5 refresh keeps data", rd_data, pat(511));
    rd_en_n = 1'b0;
    rd_edges(1);
    chk(rd_data == 9'h155, "R3 word after refresh", rd_data, 9'h155);
    chk(occ_code == 2'b00, "R1 back to empty", occ_code, 0);
    rd_en_n = 1'b1;

    // ---------- random phase, both clocks free ----------
    model_q.delete();
    rd_run = 1'b1;
    rnd_done = 1'b0;
    fork
      begin
        bit pend;
        pend = 1'b0;
        exp_w = '0;
        @(negedge rd_clk);
        last = rd_data;
        for (int n = 0; n < 4000; n++) begin
          @(negedge rd_clk);
          if (pend) chk(rd_data == exp_w, "R3 random order", rd_data, exp_w);
          else      chk(rd_data == last, "R7 random hold", rd_data, last);
          last = rd_data;
          if (occ_code == 2'b11)
            chk(model_q.size() >= 17, "R1 middle needs 17", model_q.size(), 17);
          if (occ_code != 2'b00)
            chk(model_q.size() >= 1, "R1 nonempty needs 1", model_q.size(), 1);
          chk(occ_code != 2'b01, "R1 no nearly full below 496", occ_code, 3);
          if (n < 1500) rd_en_n = ($urandom_range(0, 3) != 0);
          else          rd_en_n = ($urandom_range(0, 3) == 0);
          pend = !rd_en_n && (occ_code != 2'b00);
          if (pend) exp_w = model_q.pop_front();
        end
        rd_en_n = 1'b1;
        rnd_done = 1'b1;
      end
      begin
        while (!rnd_done) begin
          @(negedge wr_clk);
          if (!rnd_done && model_q.size() < 470 && $urandom_range(0, 1) == 1) begin
            wr_en_n = 1'b0;
            wr_data = 9'($urandom_range(0, 511));
            model_q.push_back(wr_data);
          end else begin
            wr_en_n = 1'b1;
          end
        end
        wr_en_n = 1'b1;
      end
    join

    // ---------- master reset mid-stream ----------
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = 9'h0AA;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    do_reset();
    model_q.delete();
    @(negedge rd_clk);
    chk(occ_code == 2'b00, "R8 code after second reset", occ_code, 0);
    chk(rd_data == 9'd0, "R8 data after second reset", rd_data, 0);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = 9'h1C3;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    repeat (6) @(negedge rd_clk);
    rd_en_n = 1'b1;
    chk(rd_data == 9'h1C3, "R8 pointers cleared by reset", rd_data, 9'h1C3);
    chk(occ_code == 2'b00, "R8 empty after one word", occ_code, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule